// File: doc/BRIEF.md
# Device Configuration Register Space

This block holds the 256-byte configuration space of one bus device. A host-side agent reads or writes it with byte, halfword or word accesses on a simple request port. Read data comes back one cycle after the request, little-endian, with the byte at the request address in bits 7:0. Identity bytes are fixed by parameters at reset and can never be written. The header-type parameter selects between an endpoint layout and a bridge layout. The two layouts differ in which bytes are protected.

Writes are split into bytes, lowest address first. Each byte passes through a protection map and through masks that clear reserved command and status bits. A full, aligned word written to an implemented base-address register takes a separate path. The value is cut down to the region's alignment and the region's type bits are forced back in. Software can therefore size a region by writing all ones and reading the result back. A one-cycle `map_update` pulse tells downstream address decoders when the command register or a base register has been rewritten.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset the space holds the following values. Vendor ID is at bytes 0x00-0x01 and device ID at 0x02-0x03. Revision is at 0x08, and the class code is at 0x09-0x0B with the programming interface in the low byte. The header type is at 0x0E. Subsystem vendor is at 0x2C-0x2D and subsystem ID at 0x2E-0x2F. The interrupt pin is at 0x3D. Each implemented base register at 0x10+4n (n=0..5) holds its type bits. Every other byte is zero, and `rsp_valid` and `map_update` are low.
- R2: A read request returns data on the next cycle with `rsp_valid` high. The byte at the request address is in bits 7:0 and each higher address is in the next higher byte.
- R3: `req_size` codes are 0 = byte, 1 = halfword, 2 = word and 3 = word. A word read is returned in full only at addresses up to 0xFC. A word read at 0xFD or 0xFE returns a halfword. A halfword read at 0xFF, or a word read at 0xFF, returns one byte. Bits above the returned length read as zero.
- R4: When the header type is 0x00 or 0x80, writes have no effect on these bytes: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x2C-0x2F, 0x30-0x33 and 0x3D.
- R5: For any other header type, the bytes protected are 0x00-0x03, 0x08-0x0B, 0x0E, 0x2C-0x2F, 0x38-0x3B and 0x3D. Bytes 0x10-0x27 and 0x30-0x33 are writable.
- R6: A word write at an aligned address 0x10+4n (n=0..5) whose region size S is non-zero stores (data AND NOT(S-1)) OR type. This happens even where R4 would protect the bytes.
- R7: A word write at 0x30 with a non-zero region size S stores data AND (NOT(S-1) OR 1), which keeps the enable bit 0.
- R8: A base-register word write to a region of size zero uses the ordinary byte path. The bytes are dropped under R4 and stored as written under R5.
- R9: A halfword or byte write to a base register, and a misaligned word write to one, uses the ordinary byte path and not the masking of R6 and R7.
- R10: Multi-byte writes store data byte k at address+k. Bytes whose address would exceed 0xFF are dropped.
- R11: Written bytes are masked before they are stored. Byte 0x05 is ANDed with 0x07, byte 0x06 with 0xB8 and byte 0x07 with 0xF9.
- R12: `map_update` is high for exactly the cycle after a write that either overlaps bytes 0x04-0x05 or takes the R6/R7 path. It is low in every other cycle.
- R13: `req_size` code 3 behaves exactly like code 2 for reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| map_update | output | 1 | Command or base register rewritten |

## Verification
Two instances run side by side, one with the endpoint layout and one with the bridge layout, so the same write patterns expose each protection map. Directed patterns include the following:
- All-ones word writes to base registers, which separate the alignment masking from plain storage.
- Word, halfword and byte writes around the command and status bytes, which separate the reserved masks from the update pulse.
- Accesses at 0xFC-0xFF, which separate read length degradation from write truncation at the top of the space.

A long run of random accesses over the whole space, covering all four size codes, is then compared cycle by cycle against a behavioural model.

// File: rtl/cfg_space_regs.sv
module cfg_space_regs #(
  parameter logic [15:0]      VENDOR_ID     = 16'h1D0F,
  parameter logic [15:0]      DEVICE_ID     = 16'hA5C3,
  parameter logic [7:0]       REVISION      = 8'h07,
  parameter logic [23:0]      CLASS_CODE    = 24'h020000,
  parameter logic [7:0]       HEADER_TYPE   = 8'h00,
  parameter logic [15:0]      SUBSYS_VENDOR = 16'h1AF4,
  parameter logic [15:0]      SUBSYS_ID     = 16'h0011,
  parameter logic [7:0]       INT_PIN       = 8'h01,
  parameter logic [6:0][31:0] REGION_SIZE   = {32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000},
  parameter logic [6:0][31:0] REGION_TYPE   = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h8}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        map_update
);

  localparam int  SPACE  = 256;
  localparam int  ROM_IX = 6;
  localparam bit  BRIDGE = !(HEADER_TYPE == 8'h00 || HEADER_TYPE == 8'h80);

  logic [7:0] cfg [SPACE];

  function automatic logic [7:0] reset_byte(input int a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 0)       v = VENDOR_ID[7:0];
    else if (a == 1)  v = VENDOR_ID[15:8];
    else if (a == 2)  v = DEVICE_ID[7:0];
    else if (a == 3)  v = DEVICE_ID[15:8];
    else if (a == 8)  v = REVISION;
    else if (a == 9)  v = CLASS_CODE[7:0];
    else if (a == 10) v = CLASS_CODE[15:8];
    else if (a == 11) v = CLASS_CODE[23:16];
    else if (a == 14) v = HEADER_TYPE;
    else if (a == 44) v = SUBSYS_VENDOR[7:0];
    else if (a == 45) v = SUBSYS_VENDOR[15:8];
    else if (a == 46) v = SUBSYS_ID[7:0];
    else if (a == 47) v = SUBSYS_ID[15:8];
    else if (a == 61) v = INT_PIN;
    else if (a >= 16 && a < 40) begin
      if (REGION_SIZE[(a - 16) / 4] != 32'h0)
        v = REGION_TYPE[(a - 16) / 4][8 * (a % 4) +: 8];
    end
    return v;
  endfunction

  function automatic logic read_only(input logic [7:0] a);
    logic common;
    common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E) ||
             (a >= 8'h2C && a <= 8'h2F) || (a == 8'h3D);
    if (BRIDGE) return common || (a >= 8'h38 && a <= 8'h3B);
    return common || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
  endfunction

  function automatic logic [7:0] keep_mask(input logic [7:0] a);
    case (a)
      8'h05:   return 8'h07;
      8'h06:   return 8'hB8;
      8'h07:   return 8'hF9;
      default: return 8'hFF;
    endcase
  endfunction

  wire wr = req_valid & req_write;
  wire rd = req_valid & ~req_write;

  wire [3:0] lane_sel = (req_size == 2'd0) ? 4'b0001 :
                        (req_size == 2'd1) ? 4'b0011 : 4'b1111;
  wire [8:0] last_addr = {1'b0, req_addr} +
                         ((req_size == 2'd0) ? 9'd0 : (req_size == 2'd1) ? 9'd1 : 9'd3);

  logic [7:0] bar_off;
  logic [2:0] reg_ix;
  logic       reg_hit;
  always_comb begin
    bar_off = req_addr - 8'h10;
    reg_ix  = bar_off[4:2];
    reg_hit = 1'b0;
    if (req_addr[1:0] == 2'b00) begin
      if (req_addr >= 8'h10 && req_addr < 8'h28) reg_hit = 1'b1;
      else if (req_addr == 8'h30) begin
        reg_hit = 1'b1;
        reg_ix  = 3'(ROM_IX);
      end
    end
  end

  wire [31:0] reg_size = REGION_SIZE[reg_ix];
  wire [31:0] reg_type = REGION_TYPE[reg_ix];
  wire        bar_path = wr && lane_sel[3] && reg_hit && (reg_size != 32'h0);
  wire [31:0] bar_value = (reg_ix == 3'(ROM_IX)) ?
                          (req_wdata & (~(reg_size - 32'd1) | 32'd1)) :
                          ((req_wdata & ~(reg_size - 32'd1)) | reg_type);
  wire        cmd_hit = wr && (req_addr <= 8'h05) && (last_addr >= 9'd4);

  logic [8:0] lane_addr [4];
  logic [3:0] lane_en;
  logic [7:0] lane_data [4];
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lane_addr[i] = {1'b0, req_addr} + 9'(i);
      lane_en[i]   = wr && !bar_path && lane_sel[i] && !lane_addr[i][8] &&
                     !read_only(lane_addr[i][7:0]);
      lane_data[i] = req_wdata[8*i +: 8] & keep_mask(lane_addr[i][7:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < SPACE; a++) cfg[a] <= reset_byte(a);
    end else if (bar_path) begin
      for (int i = 0; i < 4; i++) cfg[lane_addr[i][7:0]] <= bar_value[8*i +: 8];
    end else begin
      for (int i = 0; i < 4; i++)
        if (lane_en[i]) cfg[lane_addr[i][7:0]] <= lane_data[i];
    end
  end

  wire [31:0] rd_keep = (req_size[1] && req_addr <= 8'hFC)          ? 32'hFFFF_FFFF :
                        ((req_size != 2'd0) && req_addr <= 8'hFE)   ? 32'h0000_FFFF :
                                                                      32'h0000_00FF;
  wire [31:0] rd_word = {cfg[req_addr + 8'd3], cfg[req_addr + 8'd2],
                         cfg[req_addr + 8'd1], cfg[req_addr]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 32'h0;
      map_update <= 1'b0;
    end else begin
      rsp_valid  <= rd;
      map_update <= bar_path | cmd_hit;
      if (rd) rsp_rdata <= rd_word & rd_keep;
    end
  end

  a_r4_vendor_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({cfg[1], cfg[0]}));

  a_r11_cmd_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[5][7:3] == 5'h0);

  a_r11_status_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[6] & 8'h47) == 8'h0);

  a_r12_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h04) |=> map_update);

  a_r12_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !map_update);

  a_r2_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r3_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 8'hFF) |=> rsp_rdata[31:8] == 24'h0);

  for (genvar r = 0; r < 6; r++) begin : g_bar_chk
    if (!BRIDGE && REGION_SIZE[r] != 32'h0) begin : g_on
      localparam int B = 16 + 4 * r;
      a_r6_bar_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (({cfg[B+3], cfg[B+2], cfg[B+1], cfg[B]} & (REGION_SIZE[r] - 32'd1)) == REGION_TYPE[r]));
    end
  end

endmodule

// File: tb/cfg_space_regs_tb.sv
module cfg_space_regs_tb;

  localparam logic [6:0][31:0] SZ0 = {32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000};
  localparam logic [6:0][31:0] TY0 = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h8};
  localparam logic [6:0][31:0] SZ1 = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h100};
  localparam logic [6:0][31:0] TY1 = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  v = 2'b00;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [1:0]  size = 2'd0;
  logic [31:0] wdata = 32'h0;
  logic        rv [2];
  logic [31:0] rdat [2];
  logic        mu [2];

  always #10 clk = ~clk;

  cfg_space_regs #(
    .VENDOR_ID(16'h1D0F), .DEVICE_ID(16'hA5C3), .REVISION(8'h07), .CLASS_CODE(24'h020000),
    .HEADER_TYPE(8'h00), .SUBSYS_VENDOR(16'h1AF4), .SUBSYS_ID(16'h0011), .INT_PIN(8'h01),
    .REGION_SIZE(SZ0), .REGION_TYPE(TY0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_write(wr), .req_addr(addr),
    .req_size(size), .req_wdata(wdata), .rsp_valid(rv[0]), .rsp_rdata(rdat[0]),
    .map_update(mu[0])
  );

  cfg_space_regs #(
    .VENDOR_ID(16'h1D0F), .DEVICE_ID(16'hB001), .REVISION(8'h02), .CLASS_CODE(24'h060400),
    .HEADER_TYPE(8'h01), .SUBSYS_VENDOR(16'h0000), .SUBSYS_ID(16'h0000), .INT_PIN(8'h00),
    .REGION_SIZE(SZ1), .REGION_TYPE(TY1)
  ) u_dut_br (
    .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_write(wr), .req_addr(addr),
    .req_size(size), .req_wdata(wdata), .rsp_valid(rv[1]), .rsp_rdata(rdat[1]),
    .map_update(mu[1])
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem [2][256];
  logic        exp_v [2];
  logic [31:0] exp_d [2];
  logic        exp_m [2];
  string       exp_tag [2];

  function automatic logic [31:0] sz(int k, int r);
    return k ? SZ1[r] : SZ0[r];
  endfunction

  function automatic logic [31:0] ty(int k, int r);
    return k ? TY1[r] : TY0[r];
  endfunction

  function automatic logic [7:0] init_byte(int k, int a);
    logic [15:0] vid = 16'h1D0F;
    logic [15:0] did = k ? 16'hB001 : 16'hA5C3;
    logic [7:0]  rev = k ? 8'h02 : 8'h07;
    logic [23:0] cls = k ? 24'h060400 : 24'h020000;
    logic [7:0]  hdr = k ? 8'h01 : 8'h00;
    logic [15:0] ssv = k ? 16'h0000 : 16'h1AF4;
    logic [15:0] ssi = k ? 16'h0000 : 16'h0011;
    logic [7:0]  pin = k ? 8'h00 : 8'h01;
    case (a)
      0: return vid[7:0];   1: return vid[15:8];
      2: return did[7:0];   3: return did[15:8];
      8: return rev;        9: return cls[7:0];
      10: return cls[15:8]; 11: return cls[23:16];
      14: return hdr;
      44: return ssv[7:0];  45: return ssv[15:8];
      46: return ssi[7:0];  47: return ssi[15:8];
      61: return pin;
      default: begin
        if (a >= 16 && a < 40 && sz(k, (a - 16) / 4) != 0)
          return ty(k, (a - 16) / 4) >> (8 * (a % 4));
        return 8'h00;
      end
    endcase
  endfunction

  function automatic bit is_ro(int k, int a);
    if (a <= 3 || (a >= 8 && a <= 11) || a == 14 || (a >= 44 && a <= 47) || a == 61) return 1;
    if (k == 1) return (a >= 56 && a <= 59);
    return (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
  endfunction

  function automatic logic [7:0] msk(int a);
    if (a == 5) return 8'h07;
    if (a == 6) return 8'hB8;
    if (a == 7) return 8'hF9;
    return 8'hFF;
  endfunction

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (rv[k] !== exp_v[k] || mu[k] !== exp_m[k] || (exp_v[k] && rdat[k] !== exp_d[k])) begin
        errors++;
        $display("FAIL %s inst%0d valid %0b exp %0b map %0b exp %0b data %h exp %h",
                 exp_tag[k], k, rv[k], exp_v[k], mu[k], exp_m[k], rdat[k], exp_d[k]);
      end
    end
  endtask

  task automatic issue(int k, bit w, int a, int s, logic [31:0] d, string tag);
    int len;
    int r;
    bit pulse;
    logic [31:0] val;
    @(negedge clk);
    compare();
    for (int j = 0; j < 2; j++) begin
      exp_v[j] = 0; exp_m[j] = 0; exp_tag[j] = tag;
    end
    len = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    if (w) begin
      r = -1;
      if (a % 4 == 0 && a >= 16 && a < 40) r = (a - 16) / 4;
      else if (a == 48) r = 6;
      if (len == 4 && r >= 0 && sz(k, r) != 0) begin
        if (r == 6) val = d & (~(sz(k, r) - 1) | 32'd1);
        else        val = (d & ~(sz(k, r) - 1)) | ty(k, r);
        for (int i = 0; i < 4; i++) mem[k][a + i] = val[8*i +: 8];
        pulse = 1;
      end else begin
        for (int i = 0; i < len; i++) begin
          if (a + i > 255) break;
          if (!is_ro(k, a + i)) mem[k][a + i] = d[8*i +: 8] & msk(a + i);
        end
        pulse = (a <= 5) && (a + len - 1 >= 4);
      end
      exp_m[k] = pulse;
    end else begin
      if (s >= 2 && a <= 252) len = 4;
      else if (s >= 1 && a <= 254) len = 2;
      else len = 1;
      val = 32'h0;
      for (int i = 0; i < len; i++) val[8*i +: 8] = mem[k][a + i];
      exp_v[k] = 1; exp_d[k] = val;
    end
    v = 2'b00; v[k] = 1'b1; wr = w; addr = 8'(a); size = 2'(s); wdata = d;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    compare();
    for (int j = 0; j < 2; j++) begin
      exp_v[j] = 0; exp_m[j] = 0; exp_tag[j] = tag;
    end
    v = 2'b00; wr = 1'b0;
  endtask

  task automatic rd(int k, int a, int s, string tag);
    issue(k, 0, a, s, 32'h0, tag);
  endtask

  task automatic wt(int k, int a, int s, logic [31:0] d, string tag);
    issue(k, 1, a, s, d, tag);
  endtask

  bit done = 0;

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < 256; a++) mem[k][a] = init_byte(k, a);
      exp_v[k] = 0; exp_d[k] = 0; exp_m[k] = 0; exp_tag[k] = "R1";
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1");
    // R1: identity and base registers after reset, both layouts
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 64; a += 4) rd(k, a, 2, "R1");
    // R2: byte and halfword reads at odd offsets
    rd(0, 1, 0, "R2"); rd(0, 9, 1, "R2"); rd(0, 45, 1, "R2"); rd(0, 13, 2, "R2");
    // R4: endpoint protection
    wt(0, 0, 2, 32'hFFFF_FFFF, "R4"); rd(0, 0, 2, "R4");
    wt(0, 60, 2, 32'hFFFF_FFFF, "R4"); rd(0, 60, 2, "R4");
    wt(0, 12, 2, 32'hA5A5_A5A5, "R4"); rd(0, 12, 2, "R4");
    wt(0, 14, 0, 32'h0000_0055, "R4"); rd(0, 14, 0, "R4");
    // R6: base sizing and alignment
    wt(0, 16, 2, 32'hFFFF_FFFF, "R6"); rd(0, 16, 2, "R6");
    wt(0, 20, 2, 32'hFFFF_FFFF, "R6"); rd(0, 20, 2, "R6");
    wt(0, 16, 2, 32'h1234_5678, "R6"); rd(0, 16, 2, "R6");
    wt(1, 16, 2, 32'hFFFF_FFFF, "R6"); rd(1, 16, 2, "R6");
    // R7: expansion ROM keeps enable bit
    wt(0, 48, 2, 32'hFFFF_FFFF, "R7"); rd(0, 48, 2, "R7");
    wt(0, 48, 2, 32'hABCD_1230, "R7"); rd(0, 48, 2, "R7");
    // R8: zero-size region falls back to byte path
    wt(0, 24, 2, 32'h1111_2222, "R8"); rd(0, 24, 2, "R8");
    wt(1, 24, 2, 32'h0302_0100, "R8"); rd(1, 24, 2, "R8");
    // R9: partial or misaligned base writes
    wt(0, 16, 1, 32'h0000_FFFF, "R9"); rd(0, 16, 2, "R9");
    wt(1, 16, 1, 32'h0000_1234, "R9"); rd(1, 16, 2, "R9");
    wt(1, 17, 2, 32'hDEAD_BEEF, "R9"); rd(1, 16, 2, "R9"); rd(1, 20, 2, "R9");
    // R5: bridge protection map
    wt(1, 56, 2, 32'hFFFF_FFFF, "R5"); rd(1, 56, 2, "R5");
    wt(1, 48, 2, 32'h89AB_CDEF, "R5"); rd(1, 48, 2, "R5");
    wt(1, 32, 0, 32'h0000_005A, "R5"); rd(1, 32, 2, "R5");
    wt(1, 0, 2, 32'h0, "R5"); rd(1, 0, 2, "R5"); rd(1, 12, 2, "R5");
    // R11 and R12: command and status masks, update pulse
    wt(0, 4, 2, 32'hFFFF_FFFF, "R11"); rd(0, 4, 2, "R11");
    wt(0, 5, 0, 32'h0000_00FF, "R12"); idle("R12");
    wt(0, 6, 0, 32'h0000_00FF, "R12"); idle("R12");
    wt(0, 3, 1, 32'h0000_0000, "R12"); rd(0, 4, 2, "R12");
    wt(0, 2, 2, 32'h0000_0000, "R12"); rd(0, 4, 2, "R12");
    wt(0, 6, 1, 32'hFFFF_FFFF, "R11"); rd(0, 6, 1, "R11");
    // R10 and R3: top of the space
    wt(0, 252, 2, 32'h4433_2211, "R10"); rd(0, 252, 2, "R10");
    wt(0, 254, 2, 32'hCCDD_EEFF, "R10"); rd(0, 252, 2, "R10");
    wt(0, 255, 2, 32'h1122_3344, "R10"); rd(0, 252, 2, "R10");
    rd(0, 253, 2, "R3"); rd(0, 254, 2, "R3"); rd(0, 255, 2, "R3");
    rd(0, 255, 1, "R3"); rd(0, 254, 3, "R3");
    // R13: size code 3
    wt(0, 64, 3, 32'hCAFE_F00D, "R13"); rd(0, 64, 3, "R13"); rd(0, 16, 3, "R13");
    wt(0, 16, 3, 32'hFFFF_FFFF, "R13"); rd(0, 16, 3, "R13");
    // mixed random traffic on both layouts
    for (int n = 0; n < 2000; n++) begin
      int k = n % 2;
      int a = $urandom_range(0, 255);
      if (n % 5 == 0) a = $urandom_range(0, 63);
      issue(k, $urandom_range(0, 1), a, $urandom_range(0, 3), $urandom, "R2");
    end
    idle("R12");
    idle("R12");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule